// File: doc/BRIEF.md
# Instruction fetch line address generator

This block sits at the head of a single-thread in-order front end and produces instruction-fetch line requests, at most one per cycle. It holds the current fetch address, a three-way fetch state, and a pair of tags (stream and prediction) that are stamped onto every request along with a running line number. Downstream logic compares the tags carried back with fetched lines against the current ones, so lines issued before a redirect can be thrown away. Requests leave over a valid/ready handshake, and a completion strobe returns one credit per finished line.

Each request is clipped so that it never runs past the next boundary of a configurable snap size and never exceeds a maximum width. The following address is the start address plus the issued length. A request may therefore begin part way into a line and still end exactly on the snap boundary.

Redirects arrive from execute and from the predictor. An execute redirect may also halt fetching, which is how the front end is drained. A wakeup carrying a PC restarts fetching after a halt, or out of reset. Issue stops whenever the number of outstanding lines reaches a fixed limit.

Top module: `fetch_line_gen`

## Requirements
- R1: After reset the state output is 1 (waiting for a PC), `req_valid` and `drained` are low, the tags and line number are 0, and no line is in flight.
- R2: The state output is encoded 0 halted, 1 waiting for a PC, 2 running. A `wake_valid` in state 0 or 1 moves the block to 2 with the fetch address set to `wake_pc`. A wakeup in state 2 has no effect.
- R3: `req_valid` is high only in the running state while the outstanding count is below `FETCH_LIMIT`.
- R4: `req_len` equals min(`MAX_WIDTH`, `SNAP` - (`req_addr` mod `SNAP`)), so a request never crosses a snap boundary.
- R5: After an accepted request with no redirect, the next `req_addr` is the old address plus the old length. `req_lineseq` rises by one (modulo 2^`SEQ_W`) for every accepted request, and this includes requests accepted in a redirect cycle.
- R6: The outstanding count rises by one per accepted request and falls by one per `line_done`, and a `line_done` with nothing outstanding is ignored. The count never exceeds `FETCH_LIMIT`.
- R7: An execute redirect loads `exe_stream` and `exe_pred` into the tags and `exe_target` into the address. Without the halt flag it moves the block to the running state from any state.
- R8: An execute redirect with `exe_halt` set moves the block to state 0, and no request is offered until the next wakeup.
- R9: A predictor redirect in the running state loads `prd_pred` into the prediction tag and `prd_target` into the address, and leaves the stream tag unchanged.
- R10: When execute and predictor redirects arrive in the same cycle, the execute redirect is applied and the predictor redirect is dropped.
- R11: `drained` is high exactly when the state is halted and no line is outstanding.
- R12: A predictor redirect outside the running state has no effect on the tags, the address or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wake_valid | input | 1 | Wakeup strobe |
| wake_pc | input | AW | Address at which fetching resumes on wakeup |
| exe_valid | input | 1 | Execute redirect strobe |
| exe_halt | input | 1 | Execute redirect halts fetching |
| exe_target | input | AW | Execute redirect target address |
| exe_stream | input | STREAM_W | New stream tag |
| exe_pred | input | PRED_W | New prediction tag from execute |
| prd_valid | input | 1 | Predictor redirect strobe |
| prd_target | input | AW | Predicted target address |
| prd_pred | input | PRED_W | New prediction tag from the predictor |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_addr | output | AW | Request start byte address |
| req_len | output | LEN_W | Request length in bytes |
| req_stream | output | STREAM_W | Stream tag of the request |
| req_pred | output | PRED_W | Prediction tag of the request |
| req_lineseq | output | SEQ_W | Line number of the request |
| line_done | input | 1 | One outstanding line has completed |
| fetch_state | output | 2 | Fetch state (0 halted, 1 waiting for a PC, 2 running) |
| drained | output | 1 | Halted with no line outstanding |

## Verification
The checker keeps its own count of outstanding lines, and it relies on the surroundings never raising `line_done` for a line that was not issued. The address-advance and tag checks assume that the redirect inputs hold their values only in the cycle their strobe is high. The bench keeps a model of the outstanding count and raises `line_done` only while that count is positive, apart from one directed cycle that checks a stray completion is ignored. Random redirects, wakeups and backpressure are drawn around directed cases for the snap boundary, saturation at the limit, concurrent redirects and draining.

// File: rtl/fetch_gen_pkg.sv
package fetch_gen_pkg;

  typedef enum logic [1:0] {
    FS_HALT   = 2'd0,
    FS_WAITPC = 2'd1,
    FS_RUN    = 2'd2
  } fetch_st_e;

  function automatic int unsigned len_bits(input int unsigned max_width);
    return $clog2(max_width + 1);
  endfunction

endpackage

// File: rtl/fetch_clip.sv
// Length of a request starting at addr: up to the next snap boundary,
// capped at the maximum width.
module fetch_clip #(
  parameter int unsigned AW        = 32,
  parameter int unsigned SNAP      = 16,
  parameter int unsigned MAX_WIDTH = 8,
  parameter int unsigned LEN_W     = 4
) (
  input  logic [AW-1:0]    addr,
  output logic [LEN_W-1:0] len
);
  localparam int unsigned OFF_W  = $clog2(SNAP);
  localparam int unsigned ROOM_W = OFF_W + 1;
  localparam int unsigned CMP_W  = (ROOM_W > LEN_W) ? ROOM_W : LEN_W;

  logic [OFF_W-1:0] offset;
  logic [CMP_W-1:0] room;
  logic [CMP_W-1:0] cap;

  assign offset = addr[OFF_W-1:0];
  assign room   = CMP_W'(SNAP) - CMP_W'(offset);
  assign cap    = CMP_W'(MAX_WIDTH);

  generate
    if (MAX_WIDTH >= SNAP) begin : g_snap_bound
      // the snap boundary always limits first
      assign len = LEN_W'(room);
    end else begin : g_width_bound
      assign len = (room < cap) ? LEN_W'(room) : LEN_W'(cap);
    end
  endgenerate

endmodule

// File: rtl/fetch_credit.sv
// Outstanding-line counter: one up per accepted request, one down per completion.
module fetch_credit #(
  parameter int unsigned FETCH_LIMIT = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic has_room,
  output logic empty
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             give_eff;
  logic             cnt_en;

  assign give_eff = give && (cnt_q != '0);
  assign cnt_en   = take ^ give_eff;

  always_comb begin
    cnt_d = cnt_q;
    if (take && !give_eff)      cnt_d = cnt_q + CNT_W'(1);
    else if (!take && give_eff) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign has_room = (cnt_q < CNT_W'(FETCH_LIMIT));
  assign empty    = (cnt_q == '0);

endmodule

// File: rtl/fetch_stream_ctl.sv
// Fetch state, fetch address, tags and line number.
module fetch_stream_ctl
  import fetch_gen_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned STREAM_W = 4,
  parameter int unsigned PRED_W   = 4,
  parameter int unsigned SEQ_W    = 8,
  parameter int unsigned LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake_valid,
  input  logic [AW-1:0]       wake_pc,
  input  logic                exe_valid,
  input  logic                exe_halt,
  input  logic [AW-1:0]       exe_target,
  input  logic [STREAM_W-1:0] exe_stream,
  input  logic [PRED_W-1:0]   exe_pred,
  input  logic                prd_valid,
  input  logic [AW-1:0]       prd_target,
  input  logic [PRED_W-1:0]   prd_pred,
  input  logic                fire,
  input  logic [LEN_W-1:0]    len,
  output fetch_st_e           state,
  output logic [AW-1:0]       addr,
  output logic [STREAM_W-1:0] stream_tag,
  output logic [PRED_W-1:0]   pred_tag,
  output logic [SEQ_W-1:0]    line_seq
);
  fetch_st_e           st_q, st_d;
  logic [AW-1:0]       addr_q, addr_d;
  logic [STREAM_W-1:0] str_q, str_d;
  logic [PRED_W-1:0]   prd_q, prd_d;
  logic [SEQ_W-1:0]    seq_q, seq_d;

  logic prd_take, wake_take;
  logic st_en, addr_en, str_en, prd_en, seq_en;

  // execute outranks the predictor; a wakeup only acts when not running
  assign prd_take  = prd_valid && !exe_valid && (st_q == FS_RUN);
  assign wake_take = wake_valid && !exe_valid && (st_q != FS_RUN);

  assign st_en   = exe_valid || wake_take;
  assign addr_en = exe_valid || prd_take || wake_take || fire;
  assign str_en  = exe_valid;
  assign prd_en  = exe_valid || prd_take;
  assign seq_en  = fire;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    str_d  = str_q;
    prd_d  = prd_q;
    seq_d  = seq_q + SEQ_W'(1);
    if (exe_valid) begin
      st_d   = exe_halt ? FS_HALT : FS_RUN;
      addr_d = exe_target;
      str_d  = exe_stream;
      prd_d  = exe_pred;
    end else if (prd_take) begin
      addr_d = prd_target;
      prd_d  = prd_pred;
    end else if (wake_take) begin
      st_d   = FS_RUN;
      addr_d = wake_pc;
    end else if (fire) begin
      addr_d = addr_q + AW'(len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_WAITPC;
      addr_q <= '0;
      str_q  <= '0;
      prd_q  <= '0;
      seq_q  <= '0;
    end else begin
      if (st_en)   st_q   <= st_d;
      if (addr_en) addr_q <= addr_d;
      if (str_en)  str_q  <= str_d;
      if (prd_en)  prd_q  <= prd_d;
      if (seq_en)  seq_q  <= seq_d;
    end
  end

  assign state      = st_q;
  assign addr       = addr_q;
  assign stream_tag = str_q;
  assign pred_tag   = prd_q;
  assign line_seq   = seq_q;

endmodule

// File: rtl/fetch_line_gen.sv
module fetch_line_gen
  import fetch_gen_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned SNAP        = 16,
  parameter int unsigned MAX_WIDTH   = 8,
  parameter int unsigned FETCH_LIMIT = 4,
  parameter int unsigned STREAM_W    = 4,
  parameter int unsigned PRED_W      = 4,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned LEN_W       = len_bits(MAX_WIDTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wake_valid,
  input  logic [AW-1:0]       wake_pc,
  input  logic                exe_valid,
  input  logic                exe_halt,
  input  logic [AW-1:0]       exe_target,
  input  logic [STREAM_W-1:0] exe_stream,
  input  logic [PRED_W-1:0]   exe_pred,
  input  logic                prd_valid,
  input  logic [AW-1:0]       prd_target,
  input  logic [PRED_W-1:0]   prd_pred,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  output logic [LEN_W-1:0]    req_len,
  output logic [STREAM_W-1:0] req_stream,
  output logic [PRED_W-1:0]   req_pred,
  output logic [SEQ_W-1:0]    req_lineseq,
  input  logic                line_done,
  output logic [1:0]          fetch_state,
  output logic                drained
);
  localparam int unsigned CNT_W = $clog2(FETCH_LIMIT + 1);

  fetch_st_e state;
  logic      has_room, none_out, fire;

  assign req_valid = (state == FS_RUN) && has_room;
  assign fire      = req_valid && req_ready;

  fetch_clip #(
    .AW(AW), .SNAP(SNAP), .MAX_WIDTH(MAX_WIDTH), .LEN_W(LEN_W)
  ) clip_i (
    .addr (req_addr),
    .len  (req_len)
  );

  fetch_credit #(
    .FETCH_LIMIT(FETCH_LIMIT), .CNT_W(CNT_W)
  ) credit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (fire),
    .give     (line_done),
    .has_room (has_room),
    .empty    (none_out)
  );

  fetch_stream_ctl #(
    .AW(AW), .STREAM_W(STREAM_W), .PRED_W(PRED_W), .SEQ_W(SEQ_W), .LEN_W(LEN_W)
  ) ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_valid (wake_valid),
    .wake_pc    (wake_pc),
    .exe_valid  (exe_valid),
    .exe_halt   (exe_halt),
    .exe_target (exe_target),
    .exe_stream (exe_stream),
    .exe_pred   (exe_pred),
    .prd_valid  (prd_valid),
    .prd_target (prd_target),
    .prd_pred   (prd_pred),
    .fire       (fire),
    .len        (req_len),
    .state      (state),
    .addr       (req_addr),
    .stream_tag (req_stream),
    .pred_tag   (req_pred),
    .line_seq   (req_lineseq)
  );

  assign fetch_state = state;
  assign drained     = (state == FS_HALT) && none_out;

endmodule

// File: rtl/fetch_line_gen_chk.sv
module fetch_line_gen_chk #(
  parameter int unsigned AW          = 32,
  parameter int unsigned SNAP        = 16,
  parameter int unsigned MAX_WIDTH   = 8,
  parameter int unsigned FETCH_LIMIT = 4,
  parameter int unsigned STREAM_W    = 4,
  parameter int unsigned PRED_W      = 4,
  parameter int unsigned SEQ_W       = 8,
  parameter int unsigned LEN_W       = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wake_valid,
  input logic [AW-1:0]       wake_pc,
  input logic                exe_valid,
  input logic                exe_halt,
  input logic [AW-1:0]       exe_target,
  input logic [STREAM_W-1:0] exe_stream,
  input logic [PRED_W-1:0]   exe_pred,
  input logic                prd_valid,
  input logic [AW-1:0]       prd_target,
  input logic [PRED_W-1:0]   prd_pred,
  input logic                req_valid,
  input logic                req_ready,
  input logic [AW-1:0]       req_addr,
  input logic [LEN_W-1:0]    req_len,
  input logic [STREAM_W-1:0] req_stream,
  input logic [PRED_W-1:0]   req_pred,
  input logic [SEQ_W-1:0]    req_lineseq,
  input logic                line_done,
  input logic [1:0]          fetch_state,
  input logic                drained
);
  localparam int unsigned OFF_W = $clog2(SNAP);

  int unsigned out_cnt;
  logic        hs;
  assign hs = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_cnt <= 0;
    else        out_cnt <= out_cnt + (hs ? 1 : 0) - ((line_done && out_cnt != 0) ? 1 : 0);
  end

  // R3
  valid_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (fetch_state == 2'd2));

  // R6
  limit_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (out_cnt < FETCH_LIMIT));

  // R6
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= FETCH_LIMIT);

  // R4
  len_clipped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != 0 && req_len <= MAX_WIDTH &&
                   (32'(req_addr[OFF_W-1:0]) + 32'(req_len)) <= SNAP));

  // R5
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !exe_valid && !prd_valid) |=>
      (req_addr == $past(req_addr) + AW'($past(req_len))));

  // R5
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (req_lineseq == $past(req_lineseq) + SEQ_W'(1)));

  // R8
  halt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && exe_halt) |=> (fetch_state == 2'd0 && !req_valid));

  // R10
  exe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && prd_valid) |=> (req_pred == $past(exe_pred) && req_addr == $past(exe_target)));

  // R11
  drained_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (fetch_state == 2'd0 && out_cnt == 0));

endmodule

bind fetch_line_gen fetch_line_gen_chk #(
  .AW(AW), .SNAP(SNAP), .MAX_WIDTH(MAX_WIDTH), .FETCH_LIMIT(FETCH_LIMIT),
  .STREAM_W(STREAM_W), .PRED_W(PRED_W), .SEQ_W(SEQ_W), .LEN_W(LEN_W)
) chk_i (.*);

// File: tb/fetch_line_gen_tb_top.sv
module fetch_line_gen_tb_top;
  localparam int unsigned AW    = 32;
  localparam int unsigned SNAP  = 16;
  localparam int unsigned MAXW  = 8;
  localparam int unsigned LIMIT = 4;
  localparam int unsigned SW    = 4;
  localparam int unsigned PW    = 4;
  localparam int unsigned QW    = 8;
  localparam int unsigned LW    = $clog2(MAXW + 1);

  logic clk, rst_n;
  logic wake_valid, exe_valid, exe_halt, prd_valid, req_ready, line_done;
  logic [AW-1:0] wake_pc, exe_target, prd_target;
  logic [SW-1:0] exe_stream;
  logic [PW-1:0] exe_pred, prd_pred;
  logic req_valid, drained;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [SW-1:0] req_stream;
  logic [PW-1:0] req_pred;
  logic [QW-1:0] req_lineseq;
  logic [1:0] fetch_state;

  fetch_line_gen #(
    .AW(AW), .SNAP(SNAP), .MAX_WIDTH(MAXW), .FETCH_LIMIT(LIMIT),
    .STREAM_W(SW), .PRED_W(PW), .SEQ_W(QW)
  ) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bench model
  int unsigned   m_st, m_cnt;
  logic [AW-1:0] m_addr;
  logic [SW-1:0] m_str;
  logic [PW-1:0] m_prd;
  logic [QW-1:0] m_seq;

  function automatic int unsigned exp_len(input logic [AW-1:0] a);
    int unsigned room = SNAP - (a % SNAP);
    return (room < MAXW) ? room : MAXW;
  endfunction

  function automatic bit exp_valid();
    return (m_st == 2) && (m_cnt < LIMIT);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 state", 64'(fetch_state), 64'(m_st));
    chk("R3 valid", 64'(req_valid), 64'(exp_valid()));
    chk("R4 len", 64'(req_len), 64'(exp_len(m_addr)));
    chk("R5 addr", 64'(req_addr), 64'(m_addr));
    chk("R5 lineseq", 64'(req_lineseq), 64'(m_seq));
    chk("R7 stream", 64'(req_stream), 64'(m_str));
    chk("R9 pred", 64'(req_pred), 64'(m_prd));
    chk("R11 drained", 64'(drained), 64'((m_st == 0) && (m_cnt == 0)));
  endtask

  // apply currently driven inputs to the model, then advance one cycle
  task automatic tick();
    bit fire = exp_valid() && req_ready;
    bit give = line_done && (m_cnt != 0);
    m_cnt = m_cnt + (fire ? 1 : 0) - (give ? 1 : 0);
    if (exe_valid) begin
      m_st = exe_halt ? 0 : 2; m_addr = exe_target; m_str = exe_stream; m_prd = exe_pred;
    end else if (prd_valid && m_st == 2) begin
      m_addr = prd_target; m_prd = prd_pred;
    end else if (wake_valid && m_st != 2) begin
      m_st = 2; m_addr = wake_pc;
    end else if (fire) begin
      m_addr = m_addr + AW'(exp_len(m_addr));
    end
    if (fire) m_seq = m_seq + QW'(1);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    wake_valid = 0; exe_valid = 0; exe_halt = 0; prd_valid = 0;
    req_ready = 0; line_done = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle();
    wake_pc = '0; exe_target = '0; prd_target = '0;
    exe_stream = '0; exe_pred = '0; prd_pred = '0;
    m_st = 1; m_cnt = 0; m_addr = '0; m_str = '0; m_prd = '0; m_seq = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", 64'(fetch_state), 64'd1);
    chk("R1 valid", 64'(req_valid), 64'd0);
    chk("R1 drained", 64'(drained), 64'd0);
    chk("R1 lineseq", 64'(req_lineseq), 64'd0);
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // R12: predictor redirect while waiting is ignored
    prd_valid = 1; prd_target = 32'h0000_4000; prd_pred = 4'h5;
    tick();
    idle();
    chk("R12 state", 64'(fetch_state), 64'd1);
    chk("R12 addr", 64'(req_addr), 64'd0);
    // R2 wakeup at non-zero offset
    wake_valid = 1; wake_pc = 32'h0000_1003;
    tick();
    idle();
    chk("R12 pred", 64'(req_pred), 64'd0);
    chk("R2 running", 64'(fetch_state), 64'd2);
    chk("R4 first len", 64'(req_len), 64'd8);
    // wakeup while running has no effect
    wake_valid = 1; wake_pc = 32'h0000_9000;
    tick();
    idle();
    chk("R2 ignored", 64'(req_addr), 64'h1003);
    // stream of accepted requests up to the limit
    req_ready = 1;
    tick();
    chk("R4 clip", 64'(req_len), 64'd5);
    chk("R5 addr", 64'(req_addr), 64'h100B);
    tick();
    chk("R5 snap", 64'(req_addr), 64'h1010);
    tick(); tick();
    chk("R6 limit", 64'(req_valid), 64'd0);
    tick();
    chk("R6 held", 64'(req_addr), 64'h1020);
    req_ready = 0; line_done = 1;
    tick();
    idle();
    chk("R6 room", 64'(req_valid), 64'd1);
    // R9 predictor redirect
    prd_valid = 1; prd_target = 32'h0000_2004; prd_pred = 4'h3;
    tick();
    idle();
    chk("R9 pred", 64'(req_pred), 64'd3);
    chk("R9 stream", 64'(req_stream), 64'd0);
    // R10 both redirects together, with an accept in the same cycle
    exe_valid = 1; exe_target = 32'h0000_3000; exe_stream = 4'h1; exe_pred = 4'h9;
    prd_valid = 1; prd_target = 32'h0000_5000; prd_pred = 4'h6; req_ready = 1;
    tick();
    idle();
    chk("R10 pred", 64'(req_pred), 64'd9);
    chk("R10 addr", 64'(req_addr), 64'h3000);
    chk("R7 stream", 64'(req_stream), 64'd1);
    // R8 halt, then drain
    exe_valid = 1; exe_halt = 1; exe_target = 32'h0000_0040; exe_stream = 4'h2; exe_pred = 4'h2;
    tick();
    idle();
    chk("R8 halted", 64'(fetch_state), 64'd0);
    chk("R8 no req", 64'(req_valid), 64'd0);
    while (m_cnt != 0) begin
      chk("R11 not drained", 64'(drained), 64'd0);
      line_done = 1; tick();
    end
    idle();
    chk("R11 drained", 64'(drained), 64'd1);
    line_done = 1;  // stray completion, ignored
    tick();
    idle();
    chk("R6 stray", 64'(drained), 64'd1);
    // R7 non-halt redirect out of halted
    exe_valid = 1; exe_target = 32'h0000_0104; exe_stream = 4'h7; exe_pred = 4'h1;
    tick();
    idle();
    chk("R7 run", 64'(fetch_state), 64'd2);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      idle();
      req_ready = ($urandom_range(0, 9) < 7);
      line_done = (m_cnt != 0) && ($urandom_range(0, 9) < 4);
      if (r < 3) begin
        exe_valid = 1; exe_halt = ($urandom_range(0, 2) == 0);
        exe_target = $urandom; exe_stream = SW'($urandom); exe_pred = PW'($urandom);
      end
      if (r >= 2 && r < 8) begin
        prd_valid = 1; prd_target = $urandom; prd_pred = PW'($urandom);
      end
      if ($urandom_range(0, 9) == 0) begin
        wake_valid = 1; wake_pc = $urandom;
      end
      tick();
    end
    idle();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule